// File: doc/BRIEF.md
# Four-Lane Bonded Frame Receiver with Single-Error Correction

The block sits where four parallel link lanes enter a trigger processing pipeline. Each lane delivers one 24-bit frame per bunch crossing, cut into three bytes that arrive on successive link beats. The first byte of each frame is tagged by a start flag. The receiver rebuilds each lane's frame and runs a Hamming check on it. A bad bit is repaired where the code allows. The result goes into a small per-lane queue that absorbs short-term skew between the lanes.

A crossing marker sets the local phase. At a fixed phase in the following crossing, the block takes one frame from every lane, but only if all four lanes hold one. It presents the 76-bit bonded record together with per-lane corrected and uncorrectable flags. The same record then streams out as four 19-bit pipeline words, one every third clock, lane 0 first. Both rates come from a single clock with twelve ticks per crossing: link beats arrive every fourth tick and pipeline words leave every third tick. A lane whose queue runs too far ahead of the slowest lane raises a sticky alignment flag.

Top module: `bonded_link_rx`

## Requirements
- R1: In a 24-bit frame, positions 1, 2, 4, 8 and 16 are check bits. Position p is bit p-1 of the frame. The syndrome is the XOR of the positions of all set bits. A syndrome from 1 to 24 inverts that position and sets the lane's bit in `rec_corr`.
- R2: A syndrome from 25 to 31 sets the lane's bit in `rec_uncorr`. In that case the payload is taken from the received bits without change. No frame raises both flags.
- R3: A frame is three bytes taken on `lane_vld` beats. The byte that carries `lane_sof` becomes frame bits [7:0], the next byte bits [15:8] and the third byte bits [23:16]. Payload bit j is the j-th non-check position in ascending order.
- R4: A record is produced only when every lane holds a frame. If a lane misses a crossing, no record and no pipeline word is produced for it.
- R5: A frame whose last beat arrives in crossing n appears on `rec_data` during the cycle after the clock edge 6 cycles past the `bx_mark` edge of crossing n+1. `rec_valid` is high for that one cycle. Lane i occupies `rec_data[19*i+18:19*i]`.
- R6: Each record yields four `pipe_vld` pulses three cycles apart. Word k carries lane k's payload with `pipe_idx` = k. The first word coincides with `rec_valid`.
- R7: A lane whose beats trail the others by one link beat still bonds into the record of the same crossing.
- R8: A lane's bit in `align_err` sets when its queue holds more than 2 frames beyond the emptiest lane. It stays set until reset, and is zero in normal operation.
- R9: After reset `rec_valid`, `pipe_vld`, `pipe_word`, `rec_data` and `align_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock, 12 ticks per crossing |
| rst | input | 1 | Synchronous reset, active high |
| bx_mark | input | 1 | One-cycle crossing marker |
| lane_vld | input | 4 | Per-lane byte beat strobe |
| lane_sof | input | 4 | Per-lane frame start flag |
| lane_byte | input | 32 | Per-lane byte, lane i at [8i+7:8i] |
| rec_valid | output | 1 | Bonded record strobe |
| rec_data | output | 76 | Bonded payloads, lane 0 lowest |
| rec_corr | output | 4 | Per-lane corrected flag of the record |
| rec_uncorr | output | 4 | Per-lane uncorrectable flag of the record |
| pipe_vld | output | 1 | Pipeline word strobe |
| pipe_word | output | 19 | Pipeline word payload |
| pipe_idx | output | 2 | Lane index of the pipeline word |
| align_err | output | 4 | Sticky per-lane drift flags |

## Verification
The hardest state to reach from the ports is a queue imbalance of more than two frames. Ordinary crossings keep every lane within one frame of the others. To get there, the bench feeds a single lane for three crossings while the other three stay silent. It then feeds only the other three lanes, to show the flag stays set once the queues rebalance. For the code, a sweep places a single flipped bit at every one of the 24 positions on every lane. It then flips pairs that include position 24, which produces every syndrome above 24.

// File: rtl/blr_pkg.sv
package blr_pkg;

   function automatic bit blr_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // number of payload positions in a frame of the given width
   function automatic int unsigned blr_payload_bits(input int unsigned frame_w);
      int unsigned n;
      n = 0;
      for (int unsigned p = 1; p <= frame_w; p++)
         if (!blr_is_pow2(p)) n++;
      return n;
   endfunction

   // 1-based frame position of payload bit j
   function automatic int unsigned blr_data_pos(input int unsigned j);
      int unsigned cnt;
      cnt = 0;
      for (int unsigned p = 1; p <= 256; p++) begin
         if (!blr_is_pow2(p)) begin
            if (cnt == j) return p;
            cnt++;
         end
      end
      return 3;
   endfunction

endpackage

// File: rtl/blr_hamming_dec.sv
module blr_hamming_dec
   import blr_pkg::*;
#(
   parameter int unsigned FRAME_W = 24,
   parameter int unsigned PAY_W   = 19
) (
   input  logic [FRAME_W-1:0] frame,
   output logic [PAY_W-1:0]   data,
   output logic               corr,
   output logic               uncorr,
   output logic               clean
);
   localparam int unsigned SYN_W = $clog2(FRAME_W + 1);

   if (blr_payload_bits(FRAME_W) != PAY_W) begin : g_bad_width
      $error("PAY_W does not match the payload positions of FRAME_W");
   end

   logic [SYN_W-1:0]   syn;
   logic [SYN_W-1:0]   syn_fix;
   logic [FRAME_W-1:0] fixed;

   always_comb begin
      syn = '0;
      for (int p = 1; p <= FRAME_W; p++)
         if (frame[p-1]) syn = syn ^ SYN_W'(p);
      fixed  = frame;
      corr   = 1'b0;
      uncorr = 1'b0;
      if (syn != '0) begin
         if (32'(syn) <= FRAME_W) begin
            fixed[syn - SYN_W'(1)] = ~frame[syn - SYN_W'(1)];
            corr = 1'b1;
         end else begin
            uncorr = 1'b1;
         end
      end
   end

   // syndrome of the repaired word, observed by the lane checker
   always_comb begin
      syn_fix = '0;
      for (int p = 1; p <= FRAME_W; p++)
         if (fixed[p-1]) syn_fix = syn_fix ^ SYN_W'(p);
      clean = (syn_fix == '0);
   end

   for (genvar j = 0; j < PAY_W; j++) begin : g_map
      localparam int unsigned POS = blr_data_pos(j);
      assign data[j] = fixed[POS-1];
   end

endmodule

// File: rtl/blr_lane_fifo.sv
module blr_lane_fifo #(
   parameter int unsigned WIDTH = 21,
   parameter int unsigned DEPTH = 4
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         push,
   input  logic [WIDTH-1:0]             wdata,
   input  logic                         pop,
   output logic [WIDTH-1:0]             rdata,
   output logic [$clog2(DEPTH+1)-1:0]   level,
   output logic                         empty
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [CNT_W-1:0] cnt;
   logic             wr_ok, rd_ok;

   assign wr_ok = push && (cnt != CNT_W'(DEPTH));
   assign rd_ok = pop && (cnt != '0);
   assign rdata = mem[rd_ptr];
   assign level = cnt;
   assign empty = (cnt == '0);

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (wr_ok) wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + PTR_W'(1);
         if (rd_ok) rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + PTR_W'(1);
         cnt <= cnt + CNT_W'(wr_ok) - CNT_W'(rd_ok);
      end
   end

   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
      pop |-> !empty) else $error("pop on empty lane queue"); // R4

endmodule

// File: rtl/blr_lane_rx.sv
module blr_lane_rx #(
   parameter int unsigned FRAME_W = 24,
   parameter int unsigned BEAT_W  = 8,
   parameter int unsigned PAY_W   = 19,
   parameter int unsigned DEPTH   = 4
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        vld,
   input  logic                        sof,
   input  logic [BEAT_W-1:0]           beat,
   input  logic                        pop,
   output logic [PAY_W-1:0]            head_data,
   output logic                        head_corr,
   output logic                        head_uncorr,
   output logic [$clog2(DEPTH+1)-1:0]  level,
   output logic                        empty
);
   localparam int unsigned BEATS = FRAME_W / BEAT_W;
   localparam int unsigned ACC_W = FRAME_W - BEAT_W;
   localparam int unsigned BI_W  = $clog2(BEATS);
   localparam int unsigned ENT_W = PAY_W + 2;

   if ((BEATS < 2) || (BEATS * BEAT_W != FRAME_W)) begin : g_bad_beats
      $error("FRAME_W must be a multiple (at least 2) of BEAT_W");
   end

   logic [BI_W-1:0]    beat_idx;
   logic [ACC_W-1:0]   acc;
   logic [FRAME_W-1:0] frame_q;
   logic               push_q;
   logic [PAY_W-1:0]   dec_data;
   logic               dec_corr, dec_uncorr, dec_clean;
   logic [ENT_W-1:0]   head;

   always_ff @(posedge clk) begin
      if (rst) begin
         beat_idx <= '0;
         acc      <= '0;
         frame_q  <= '0;
         push_q   <= 1'b0;
      end else begin
         push_q <= 1'b0;
         if (vld) begin
            if (sof) begin
               acc[BEAT_W-1:0] <= beat;
               beat_idx        <= BI_W'(1);
            end else if (beat_idx != '0) begin
               if (beat_idx == BI_W'(BEATS-1)) begin
                  frame_q  <= {beat, acc};
                  push_q   <= 1'b1;
                  beat_idx <= '0;
               end else begin
                  acc[32'(beat_idx)*BEAT_W +: BEAT_W] <= beat;
                  beat_idx <= beat_idx + BI_W'(1);
               end
            end
         end
      end
   end

   blr_hamming_dec #(.FRAME_W(FRAME_W), .PAY_W(PAY_W)) i_dec (
      .frame  (frame_q),
      .data   (dec_data),
      .corr   (dec_corr),
      .uncorr (dec_uncorr),
      .clean  (dec_clean)
   );

   blr_lane_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) i_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (push_q),
      .wdata ({dec_uncorr, dec_corr, dec_data}),
      .pop   (pop),
      .rdata (head),
      .level (level),
      .empty (empty)
   );

   assign head_data   = head[PAY_W-1:0];
   assign head_corr   = head[PAY_W];
   assign head_uncorr = head[PAY_W+1];

   AST_REPAIR_CLEAN: assert property (@(posedge clk) disable iff (rst)
      (push_q && dec_corr) |-> dec_clean) else $error("repaired frame keeps a syndrome"); // R1

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
      push_q |-> !(dec_corr && dec_uncorr)) else $error("both code flags set"); // R2

endmodule

// File: rtl/bonded_link_rx.sv
module bonded_link_rx
   import blr_pkg::*;
#(
   parameter int unsigned LANES        = 4,
   parameter int unsigned PAY_W        = 19,
   parameter int unsigned FRAME_W      = 24,
   parameter int unsigned BEAT_W       = 8,
   parameter int unsigned DEPTH        = 4,
   parameter int unsigned SKEW_TOL     = 2,
   parameter int unsigned TICKS_PER_BX = 12,
   parameter int unsigned POP_PHASE    = 6,
   parameter int unsigned WORD_GAP     = 3
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       bx_mark,
   input  logic [LANES-1:0]           lane_vld,
   input  logic [LANES-1:0]           lane_sof,
   input  logic [LANES*BEAT_W-1:0]    lane_byte,
   output logic                       rec_valid,
   output logic [LANES*PAY_W-1:0]     rec_data,
   output logic [LANES-1:0]           rec_corr,
   output logic [LANES-1:0]           rec_uncorr,
   output logic                       pipe_vld,
   output logic [PAY_W-1:0]           pipe_word,
   output logic [$clog2(LANES)-1:0]   pipe_idx,
   output logic [LANES-1:0]           align_err
);
   localparam int unsigned REC_W = LANES * PAY_W;
   localparam int unsigned IDX_W = $clog2(LANES);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);
   localparam int unsigned PH_W  = $clog2(TICKS_PER_BX);
   localparam int unsigned GAP_W = (WORD_GAP > 1) ? $clog2(WORD_GAP) : 1;

   if (LANES < 2) begin : g_bad_lanes
      $error("LANES must be at least 2");
   end
   if (LANES * WORD_GAP > TICKS_PER_BX) begin : g_bad_rate
      $error("pipeline words of one record exceed one crossing");
   end
   if ((POP_PHASE == 0) || (POP_PHASE >= TICKS_PER_BX)) begin : g_bad_phase
      $error("POP_PHASE must lie inside the crossing");
   end
   if (SKEW_TOL >= DEPTH) begin : g_bad_tol
      $error("SKEW_TOL must be below DEPTH");
   end

   logic [PAY_W-1:0] lane_data [LANES];
   logic [CNT_W-1:0] lane_lvl  [LANES];
   logic [LANES-1:0] lane_empty, lane_corr, lane_uncorr, drift;
   logic [REC_W-1:0] heads;
   logic [PH_W-1:0]  ph;
   logic [GAP_W-1:0] gap;
   logic             streaming, all_ready, pop_go;
   logic [CNT_W-1:0] lvl_min;

   assign all_ready = ~|lane_empty;
   assign pop_go    = (ph == PH_W'(POP_PHASE-1)) && all_ready;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      blr_lane_rx #(
         .FRAME_W (FRAME_W),
         .BEAT_W  (BEAT_W),
         .PAY_W   (PAY_W),
         .DEPTH   (DEPTH)
      ) i_lane (
         .clk         (clk),
         .rst         (rst),
         .vld         (lane_vld[i]),
         .sof         (lane_sof[i]),
         .beat        (lane_byte[i*BEAT_W +: BEAT_W]),
         .pop         (pop_go),
         .head_data   (lane_data[i]),
         .head_corr   (lane_corr[i]),
         .head_uncorr (lane_uncorr[i]),
         .level       (lane_lvl[i]),
         .empty       (lane_empty[i])
      );
      assign heads[i*PAY_W +: PAY_W] = lane_data[i];
   end

   // crossing phase, restarted by the marker
   always_ff @(posedge clk) begin
      if (rst)                                ph <= '0;
      else if (bx_mark)                       ph <= '0;
      else if (ph != PH_W'(TICKS_PER_BX-1))   ph <= ph + PH_W'(1);
   end

   // drift against the emptiest lane
   always_comb begin
      lvl_min = lane_lvl[0];
      for (int i = 1; i < LANES; i++)
         if (lane_lvl[i] < lvl_min) lvl_min = lane_lvl[i];
      for (int i = 0; i < LANES; i++)
         drift[i] = 32'(lane_lvl[i]) > 32'(lvl_min) + SKEW_TOL;
   end

   always_ff @(posedge clk) begin
      if (rst) align_err <= '0;
      else     align_err <= align_err | drift;
   end

   // record capture and word streaming
   always_ff @(posedge clk) begin
      if (rst) begin
         rec_valid  <= 1'b0;
         rec_data   <= '0;
         rec_corr   <= '0;
         rec_uncorr <= '0;
         pipe_vld   <= 1'b0;
         pipe_word  <= '0;
         pipe_idx   <= '0;
         gap        <= '0;
         streaming  <= 1'b0;
      end else begin
         rec_valid <= pop_go;
         pipe_vld  <= 1'b0;
         if (pop_go) begin
            rec_data   <= heads;
            rec_corr   <= lane_corr;
            rec_uncorr <= lane_uncorr;
            pipe_word  <= lane_data[0];
            pipe_vld   <= 1'b1;
            pipe_idx   <= '0;
            gap        <= '0;
            streaming  <= 1'b1;
         end else if (streaming) begin
            if (gap == GAP_W'(WORD_GAP-1)) begin
               gap <= '0;
               if (pipe_idx == IDX_W'(LANES-1)) begin
                  streaming <= 1'b0;
               end else begin
                  pipe_idx  <= pipe_idx + IDX_W'(1);
                  pipe_word <= rec_data[(32'(pipe_idx) + 1) * PAY_W +: PAY_W];
                  pipe_vld  <= 1'b1;
               end
            end else begin
               gap <= gap + GAP_W'(1);
            end
         end
      end
   end

   AST_REC_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
      rec_valid |-> $past(all_ready)) else $error("record without all lanes"); // R4

   AST_FIRST_WORD: assert property (@(posedge clk) disable iff (rst)
      rec_valid |-> (pipe_vld && (pipe_idx == '0) && (pipe_word == rec_data[PAY_W-1:0])))
      else $error("first word does not match record"); // R5

   AST_WORD_SPACING: assert property (@(posedge clk) disable iff (rst)
      pipe_vld |=> !pipe_vld) else $error("back-to-back pipeline words"); // R6

   AST_ALIGN_STICKY: assert property (@(posedge clk) disable iff (rst)
      ((align_err & $past(align_err)) == $past(align_err))) else $error("drift flag cleared"); // R8

endmodule

// File: tb/test_bonded_link_rx.sv
module test_bonded_link_rx;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 4;
   localparam int PW = 19;
   localparam int FW = 24;

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic              rst;
   logic              bx_mark;
   logic [NL-1:0]     lane_vld, lane_sof;
   logic [NL*8-1:0]   lane_byte;
   logic              rec_valid;
   logic [NL*PW-1:0]  rec_data;
   logic [NL-1:0]     rec_corr, rec_uncorr;
   logic              pipe_vld;
   logic [PW-1:0]     pipe_word;
   logic [1:0]        pipe_idx;
   logic [NL-1:0]     align_err;

   bonded_link_rx i_bonded_link_rx (
      .clk (clk), .rst (rst), .bx_mark (bx_mark),
      .lane_vld (lane_vld), .lane_sof (lane_sof), .lane_byte (lane_byte),
      .rec_valid (rec_valid), .rec_data (rec_data),
      .rec_corr (rec_corr), .rec_uncorr (rec_uncorr),
      .pipe_vld (pipe_vld), .pipe_word (pipe_word), .pipe_idx (pipe_idx),
      .align_err (align_err)
   );

   int checks = 0;
   int errors = 0;
   int g = 0;
   bit chk_on = 1'b1;
   string tag_valid = "R5";

   logic [PW-1:0] exp_d [64][NL];
   logic [NL-1:0] exp_c [64];
   logic [NL-1:0] exp_u [64];
   bit            exp_v [64];
   logic [NL-1:0]      car_v;
   logic [NL-1:0][7:0] car_b;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [NL*PW-1:0] act, input logic [NL*PW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] enc(input logic [PW-1:0] d);
      logic [FW-1:0] f;
      int k;
      f = '0;
      k = 0;
      for (int p = 1; p <= FW; p++)
         if ((p & (p - 1)) != 0) begin f[p-1] = d[k]; k++; end
      for (int q = 1; q <= 16; q = q * 2) begin
         logic b;
         b = 1'b0;
         for (int p = 1; p <= FW; p++)
            if (((p & q) != 0) && (p != q)) b = b ^ f[p-1];
         f[q-1] = b;
      end
      return f;
   endfunction

   function automatic void mdec(input logic [FW-1:0] f, output logic [PW-1:0] d,
                                output logic c, output logic u);
      int s;
      int k;
      s = 0;
      for (int p = 1; p <= FW; p++) if (f[p-1]) s = s ^ p;
      c = 1'b0;
      u = 1'b0;
      if (s >= 1 && s <= FW) begin f[s-1] = ~f[s-1]; c = 1'b1; end
      else if (s > FW) u = 1'b1;
      k = 0;
      d = '0;
      for (int p = 1; p <= FW; p++)
         if ((p & (p - 1)) != 0) begin d[k] = f[p-1]; k++; end
   endfunction

   function automatic logic [PW-1:0] pat(input int r, input int l);
      return PW'((r * 7919 + l * 40503 + 12345) ^ (r << 11));
   endfunction

   task automatic check_cycle();
      int off;
      off = g - 6;
      if (!chk_on) return;
      if (off >= 12 && (off % 3) == 0) begin
         int r;
         int w;
         logic [NL*PW-1:0] ev;
         r = off / 12 - 1;
         w = (off % 12) / 3;
         for (int l = 0; l < NL; l++) ev[l*PW +: PW] = exp_d[r%64][l];
         chk(pipe_vld == exp_v[r%64], "R6", "pipe_vld", 76'(pipe_vld), 76'(exp_v[r%64]));
         if (exp_v[r%64])
            chk(pipe_word == exp_d[r%64][w] && pipe_idx == 2'(w), "R6", "pipe word/idx",
                76'({pipe_idx, pipe_word}), 76'({2'(w), exp_d[r%64][w]}));
         if (w == 0) begin
            chk(rec_valid == exp_v[r%64], tag_valid, "rec_valid", 76'(rec_valid), 76'(exp_v[r%64]));
            if (exp_v[r%64]) begin
               chk(rec_data == ev, "R3", "rec_data", rec_data, ev);
               chk(rec_corr == exp_c[r%64], "R1", "rec_corr", 76'(rec_corr), 76'(exp_c[r%64]));
               chk(rec_uncorr == exp_u[r%64], "R2", "rec_uncorr", 76'(rec_uncorr), 76'(exp_u[r%64]));
            end
         end
      end else begin
         chk(!pipe_vld && !rec_valid, "R6", "idle strobes", 76'({rec_valid, pipe_vld}), 76'(0));
      end
   endtask

   task automatic run_bx(input logic [NL-1:0][PW-1:0] d, input logic [NL-1:0][FW-1:0] fm,
                         input logic [NL-1:0] en, input int late_lane);
      int r;
      logic [NL-1:0][FW-1:0] fr;
      r = g / 12;
      for (int l = 0; l < NL; l++) begin
         logic [PW-1:0] dd;
         logic cc, uu;
         fr[l] = enc(d[l]) ^ fm[l];
         mdec(fr[l], dd, cc, uu);
         exp_d[r%64][l] = dd;
         exp_c[r%64][l] = cc;
         exp_u[r%64][l] = uu;
      end
      exp_v[r%64] = &en;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         bx_mark   = (c == 0);
         lane_vld  = '0;
         lane_sof  = '0;
         lane_byte = '0;
         for (int l = 0; l < NL; l++) begin
            if (c == 0 && car_v[l]) begin
               lane_vld[l] = 1'b1;
               lane_byte[l*8 +: 8] = car_b[l];
               car_v[l] = 1'b0;
            end
            if (en[l]) begin
               for (int b = 0; b < 3; b++) begin
                  int t;
                  t = 4 * b + ((l == late_lane) ? 4 : 0);
                  if (t == c) begin
                     lane_vld[l] = 1'b1;
                     lane_sof[l] = (b == 0);
                     lane_byte[l*8 +: 8] = fr[l][8*b +: 8];
                  end else if (t >= 12 && c == 11) begin
                     car_v[l] = 1'b1;
                     car_b[l] = fr[l][8*b +: 8];
                  end
               end
            end
         end
         @(posedge clk);
         #1;
         check_cycle();
         g++;
      end
   endtask

   task automatic idle_bx();
      run_bx('0, '0, '0, -1);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      bx_mark = 1'b0;
      lane_vld = '0;
      lane_sof = '0;
      lane_byte = '0;
      car_v = '0;
      car_b = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(posedge clk);
      #1;
      g = 0;
      for (int i = 0; i < 64; i++) exp_v[i] = 1'b0;
   endtask

   bit done = 1'b0;
   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [NL-1:0][PW-1:0] d;
      logic [NL-1:0][FW-1:0] fm;
      rst = 1'b1;
      do_reset();
      // R9 reset state
      chk(!rec_valid && !pipe_vld && pipe_word == '0 && rec_data == '0 && align_err == '0,
          "R9", "reset outputs", 76'({rec_valid, pipe_vld, align_err, pipe_word}), 76'(0));

      // single-bit sweep: every position on every lane (R1)
      for (int r = 0; r < 24; r++) begin
         for (int l = 0; l < NL; l++) begin
            d[l]  = pat(r, l);
            fm[l] = FW'(1) << ((r + 6 * l) % 24);
         end
         run_bx(d, fm, 4'hF, -1);
      end
      // double flips with position 24: syndromes 25..31 (R2)
      for (int r = 0; r < 7; r++) begin
         for (int l = 0; l < NL; l++) begin
            d[l]  = pat(r + 40, l);
            fm[l] = 24'h800000 | (FW'(1) << ((r + l) % 7));
         end
         run_bx(d, fm, 4'hF, -1);
      end
      // clean frames: zeros, ones, pattern (R3)
      run_bx('0, '0, 4'hF, -1);
      for (int l = 0; l < NL; l++) d[l] = '1;
      run_bx(d, '0, 4'hF, -1);
      for (int l = 0; l < NL; l++) d[l] = pat(77, l);
      run_bx(d, '0, 4'hF, -1);
      idle_bx();
      idle_bx();
      chk(align_err == '0, "R8", "no drift in normal run", 76'(align_err), 76'(0));

      // one lane a beat late still bonds (R7)
      do_reset();
      tag_valid = "R7";
      for (int r = 0; r < 4; r++) begin
         for (int l = 0; l < NL; l++) d[l] = pat(r + 90, l);
         run_bx(d, '0, 4'hF, 3);
      end
      idle_bx();
      idle_bx();
      chk(align_err == '0, "R7", "skew within tolerance", 76'(align_err), 76'(0));

      // missing lane: no record (R4)
      do_reset();
      tag_valid = "R4";
      for (int l = 0; l < NL; l++) d[l] = pat(5, l);
      run_bx(d, '0, 4'b1011, -1);
      idle_bx();
      idle_bx();
      tag_valid = "R5";

      // drift of one lane (R8)
      do_reset();
      chk_on = 1'b0;
      for (int l = 0; l < NL; l++) d[l] = pat(7, l);
      run_bx(d, '0, 4'b0100, -1);
      run_bx(d, '0, 4'b0100, -1);
      chk(align_err == '0, "R8", "two frames ahead", 76'(align_err), 76'(0));
      run_bx(d, '0, 4'b0100, -1);
      chk(align_err == 4'b0100, "R8", "three frames ahead", 76'(align_err), 76'(4'b0100));
      run_bx(d, '0, 4'b1011, -1);
      run_bx(d, '0, 4'b1011, -1);
      run_bx(d, '0, 4'b1011, -1);
      chk(align_err == 4'b0100, "R8", "flag sticky", 76'(align_err), 76'(4'b0100));
      do_reset();
      chk(align_err == '0, "R8", "cleared by reset", 76'(align_err), 76'(0));
      chk_on = 1'b1;

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule